// File: doc/BRIEF.md
# Duplicate-Tag Snoop Filter Controller

This block keeps cache coherence for a cluster of one to four small processor caches. It holds a shadow copy of each cache's line tags and MESI state, and uses these shadows as a local directory. A cache that misses, wants ownership, or gives up a line sends a request. The controller looks up every shadow in the same cycle. It then decides which peer caches must be probed, where the data comes from (a peer cache or memory), and the new state of the line in every cache involved.

Requests are granted one per cycle in round-robin order. The decision appears on registered outputs in the following cycle: a snoop bundle (invalidate and share masks, a data-source mask and the line address), a memory request, and a response that gives the requester its final state. Clean lines are handed over cache to cache. Dirty lines migrate to the requester without passing through Shared. A per-CPU heuristic stops allocating lines during long runs of sequential full-line writes, and a powered-down CPU drops out of the directory.

Top module: `snoop_filter_ctrl`

## Requirements
- R1: Encodings: request ops are 0 read miss, 1 read-for-ownership, 2 clean eviction, 3 writeback; line states are 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified. After reset no line is held, and no grant, response, snoop or memory request is active. A read that no other cache holds issues one memory read of the line and gives the requester Exclusive with no snoop.
- R2: Invalidate and share commands go only to the CPUs whose shadow shows the line as valid, and never to the requester.
- R3: A read that finds only clean holders sends share to every holder and takes data from the lowest-numbered holder. Holders and requester end in Shared, and no memory request is made.
- R4: A read that finds a Modified holder invalidates that holder and takes data from it. The requester ends in Modified, no share command is sent and no memory request is made.
- R5: A read-for-ownership invalidates every other holder, and the requester ends in Modified. Data comes from a Modified holder if there is one, otherwise from the lowest-numbered clean holder, and from memory (a read) only when nobody holds the line.
- R6: A clean eviction clears the requester's shadow entry with no snoop and no memory request. A writeback clears it and issues a memory write of the line. A later read by another CPU then goes to memory.
- R7: While a CPU's power-off bit is set, its shadow counts as empty, it receives no snoop and is never a data source, and its own requests are not granted.
- R8: Within one CPU, the fourth and every further full-line read-for-ownership to consecutive line addresses is not allocated. Other holders are still invalidated, a memory write is issued and the response state is Invalid. A read miss, a partial read-for-ownership, or a full-line write to a non-consecutive address starts the count again.
- R9: At most one grant per cycle, only to a CPU that is requesting and powered. Among the requesters the grant goes to the first one at or after the CPU following the last granted CPU.
- R10: No request is granted while the memory channel is not ready.
- R11: The response, snoop and memory outputs are one-cycle pulses in the cycle after the grant. The shadows are updated at that same clock edge, so a request granted in the next cycle sees the new state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_off | input | N | Per-CPU power-off flag |
| req_valid | input | N | Per-CPU request, held until granted |
| req_op | input | 2*N | Per-CPU op code, CPU j in bits [2j+1:2j] |
| req_full | input | N | Per-CPU full-line write flag for read-for-ownership |
| req_addr | input | AW*N | Per-CPU line address, CPU j in bits [AW*j+AW-1:AW*j] |
| mem_ready | input | 1 | Memory channel can accept a request |
| req_grant | output | N | One-hot grant, combinational |
| resp_valid | output | 1 | Decision pulse |
| resp_cpu | output | CW | Index of the CPU the decision is for |
| resp_state | output | 2 | Requester's final line state |
| snp_inval | output | N | Invalidate command mask |
| snp_share | output | N | Downgrade-to-shared command mask |
| snp_source | output | N | Cache that supplies the data |
| snp_addr | output | AW | Line address of the snoop |
| mem_req_valid | output | 1 | Memory request pulse |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_addr | output | AW | Memory request line address |

## Verification
The hardest situation to reach is a run of requests for one line from several CPUs that are granted back to back. In it, each decision depends on the shadow write made one edge earlier, and the grant order comes from the arbiter's pointer. The bench raises read requests for one fresh line on all CPUs in the same cycle and records the order of the grants. The first CPU granted must go to memory and get Exclusive. Every later CPU must get Shared, with the earlier grantees as share targets and the lowest of them as source. The migration chain and the back-off run are driven as sequences on one CPU or one line, so each step depends on the state the previous step left.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int MAX_CPU = 4;

  localparam logic [1:0] ST_I = 2'd0;
  localparam logic [1:0] ST_S = 2'd1;
  localparam logic [1:0] ST_E = 2'd2;
  localparam logic [1:0] ST_M = 2'd3;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_RFO   = 2'd1;
  localparam logic [1:0] OP_EVICT = 2'd2;
  localparam logic [1:0] OP_WB    = 2'd3;

  // isolate the lowest set bit of a CPU mask
  function automatic logic [MAX_CPU-1:0] lowest_one(input logic [MAX_CPU-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  // next length of a streaming-write run
  function automatic int unsigned next_run(input logic full_write, input logic sequential,
                                           input logic restart, input int unsigned run,
                                           input int unsigned cap);
    if (full_write) begin
      if (sequential) return (run >= cap) ? cap : run + 1;
      return 1;
    end
    if (restart) return 0;
    return run;
  endfunction
endpackage

// File: rtl/sfc_rr_arb.sv
module sfc_rr_arb #(
  parameter int N = 4,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          stall,
  output logic [N-1:0]  grant,
  output logic [CW-1:0] gidx,
  output logic          any
);
  logic [CW-1:0] ptr_q;

  always_comb begin
    grant = '0;
    gidx  = '0;
    any   = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!any && !stall && req[(int'(ptr_q) + k) % N]) begin
        any = 1'b1;
        grant[(int'(ptr_q) + k) % N] = 1'b1;
        gidx = CW'((int'(ptr_q) + k) % N);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (any) ptr_q <= (int'(gidx) == N - 1) ? '0 : gidx + 1'b1;
  end
endmodule

// File: rtl/sfc_dup_tags.sv
module sfc_dup_tags
  import sfc_pkg::*;
#(
  parameter int SETS = 16,
  parameter int AW   = 16,
  localparam int IW  = $clog2(SETS),
  localparam int TW  = AW - IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          powered_off,
  input  logic [AW-1:0] lk_addr,
  output logic          hit,
  output logic [1:0]    state,
  input  logic          we,
  input  logic [1:0]    wstate
);
  logic [TW-1:0] tag_q [SETS];
  logic [1:0]    st_q  [SETS];
  logic [IW-1:0] idx;
  logic [TW-1:0] tg;

  assign idx = lk_addr[IW-1:0];
  assign tg  = lk_addr[AW-1:IW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) st_q[i] <= ST_I;
    end else if (we) begin
      st_q[idx] <= wstate;
    end
  end

  always_ff @(posedge clk) begin
    if (we) tag_q[idx] <= tg;
  end

  assign hit   = !powered_off && (st_q[idx] != ST_I) && (tag_q[idx] == tg);
  assign state = hit ? st_q[idx] : ST_I;
endmodule

// File: rtl/sfc_backoff.sv
module sfc_backoff
  import sfc_pkg::*;
#(
  parameter int AW  = 16,
  parameter int RUN = 4,
  localparam int RW = $clog2(RUN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [1:0]    op,
  input  logic          full,
  input  logic [AW-1:0] addr,
  output logic          no_alloc
);
  logic [RW-1:0] run_q, run_n;
  logic [AW-1:0] last_q;
  logic full_write, sequential, restart;

  assign full_write = (op == OP_RFO) && full;
  assign sequential = (run_q != '0) && (addr == last_q + 1'b1);
  assign restart    = (op == OP_READ) || (op == OP_RFO);
  assign run_n      = RW'(next_run(full_write, sequential, restart, int'(run_q), RUN));
  assign no_alloc   = full_write && (int'(run_n) >= RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      last_q <= '0;
    end else if (upd) begin
      run_q <= run_n;
      if (full_write) last_q <= addr;
    end
  end
endmodule

// File: rtl/sfc_decide.sv
module sfc_decide
  import sfc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [1:0]        op,
  input  logic              no_alloc,
  input  logic [N-1:0]      self_oh,
  input  logic [N-1:0]      hit,
  input  logic [N-1:0][1:0] st,
  output logic [N-1:0]      snp_inval,
  output logic [N-1:0]      snp_share,
  output logic [N-1:0]      snp_src,
  output logic [N-1:0]      peer_we,
  output logic [1:0]        peer_state,
  output logic              req_we,
  output logic [1:0]        req_state,
  output logic              mem_rd,
  output logic              mem_wr
);
  logic [N-1:0] holders, dirty;
  logic self_hit;

  assign holders  = hit & ~self_oh;
  assign self_hit = |(hit & self_oh);

  always_comb begin
    for (int j = 0; j < N; j++) dirty[j] = holders[j] && (st[j] == ST_M);
  end

  always_comb begin
    snp_inval  = '0;
    snp_share  = '0;
    snp_src    = '0;
    peer_we    = '0;
    peer_state = ST_I;
    req_we     = 1'b0;
    req_state  = ST_I;
    mem_rd     = 1'b0;
    mem_wr     = 1'b0;
    unique case (op)
      OP_READ: begin
        req_we = 1'b1;
        if (|dirty) begin
          snp_inval = dirty;
          snp_src   = N'(lowest_one(MAX_CPU'(dirty)));
          peer_we   = dirty;
          req_state = ST_M;
        end else if (|holders) begin
          snp_share  = holders;
          snp_src    = N'(lowest_one(MAX_CPU'(holders)));
          peer_we    = holders;
          peer_state = ST_S;
          req_state  = ST_S;
        end else begin
          mem_rd    = 1'b1;
          req_state = ST_E;
        end
      end
      OP_RFO: begin
        snp_inval = holders;
        peer_we   = holders;
        req_we    = 1'b1;
        if (no_alloc) begin
          mem_wr    = 1'b1;
          req_state = ST_I;
        end else begin
          req_state = ST_M;
          if (|dirty)        snp_src = N'(lowest_one(MAX_CPU'(dirty)));
          else if (|holders) snp_src = N'(lowest_one(MAX_CPU'(holders)));
          else               mem_rd  = 1'b1;
        end
      end
      OP_EVICT: begin
        req_we = self_hit;
      end
      default: begin
        req_we = self_hit;
        mem_wr = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/snoop_filter_ctrl.sv
module snoop_filter_ctrl
  import sfc_pkg::*;
#(
  parameter int N    = 4,
  parameter int SETS = 16,
  parameter int AW   = 16,
  parameter int RUN  = 4,
  localparam int CW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    cpu_off,
  input  logic [N-1:0]    req_valid,
  input  logic [2*N-1:0]  req_op,
  input  logic [N-1:0]    req_full,
  input  logic [AW*N-1:0] req_addr,
  input  logic            mem_ready,
  output logic [N-1:0]    req_grant,
  output logic            resp_valid,
  output logic [CW-1:0]   resp_cpu,
  output logic [1:0]      resp_state,
  output logic [N-1:0]    snp_inval,
  output logic [N-1:0]    snp_share,
  output logic [N-1:0]    snp_source,
  output logic [AW-1:0]   snp_addr,
  output logic            mem_req_valid,
  output logic            mem_req_write,
  output logic [AW-1:0]   mem_req_addr
);
  // named internal events
  logic              grant_any;
  logic [CW-1:0]     gidx;
  logic [1:0]        sel_op;
  logic [AW-1:0]     sel_addr;
  logic [N-1:0]      no_alloc_v;
  logic [N-1:0]      hit;
  logic [N-1:0][1:0] st;
  logic [N-1:0]      d_inval, d_share, d_src, peer_we;
  logic [1:0]        peer_state, req_state;
  logic              req_we, mem_rd, mem_wr;

  sfc_rr_arb #(.N(N)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid & ~cpu_off), .stall(!mem_ready),
    .grant(req_grant), .gidx(gidx), .any(grant_any)
  );

  assign sel_op   = req_op[int'(gidx)*2 +: 2];
  assign sel_addr = req_addr[int'(gidx)*AW +: AW];

  for (genvar j = 0; j < N; j++) begin : g_cpu
    sfc_backoff #(.AW(AW), .RUN(RUN)) u_bo (
      .clk(clk), .rst_n(rst_n), .upd(req_grant[j]),
      .op(req_op[2*j +: 2]), .full(req_full[j]), .addr(req_addr[AW*j +: AW]),
      .no_alloc(no_alloc_v[j])
    );
    sfc_dup_tags #(.SETS(SETS), .AW(AW)) u_tags (
      .clk(clk), .rst_n(rst_n), .powered_off(cpu_off[j]), .lk_addr(sel_addr),
      .hit(hit[j]), .state(st[j]),
      .we(grant_any && (req_grant[j] ? req_we : peer_we[j])),
      .wstate(req_grant[j] ? req_state : peer_state)
    );
  end

  sfc_decide #(.N(N)) u_dec (
    .op(sel_op), .no_alloc(no_alloc_v[gidx]), .self_oh(req_grant), .hit(hit), .st(st),
    .snp_inval(d_inval), .snp_share(d_share), .snp_src(d_src),
    .peer_we(peer_we), .peer_state(peer_state),
    .req_we(req_we), .req_state(req_state), .mem_rd(mem_rd), .mem_wr(mem_wr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid    <= 1'b0;
      resp_cpu      <= '0;
      resp_state    <= ST_I;
      snp_inval     <= '0;
      snp_share     <= '0;
      snp_source    <= '0;
      snp_addr      <= '0;
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_addr  <= '0;
    end else begin
      resp_valid    <= grant_any;
      snp_inval     <= grant_any ? d_inval : '0;
      snp_share     <= grant_any ? d_share : '0;
      snp_source    <= grant_any ? d_src : '0;
      mem_req_valid <= grant_any && (mem_rd || mem_wr);
      mem_req_write <= grant_any && mem_wr;
      if (grant_any) begin
        resp_cpu     <= gidx;
        resp_state   <= req_state;
        snp_addr     <= sel_addr;
        mem_req_addr <= sel_addr;
      end
    end
  end
endmodule

// File: rtl/snoop_filter_checker.sv
module snoop_filter_checker
  import sfc_pkg::*;
#(
  parameter int N  = 4,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  cpu_off,
  input logic [N-1:0]  req_valid,
  input logic          mem_ready,
  input logic [N-1:0]  req_grant,
  input logic          grant_any,
  input logic          resp_valid,
  input logic [CW-1:0] resp_cpu,
  input logic [1:0]    resp_state,
  input logic [N-1:0]  snp_inval,
  input logic [N-1:0]  snp_share,
  input logic [N-1:0]  snp_source,
  input logic          mem_req_valid,
  input logic          mem_req_write
);
  assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_grant));
  assert_grant_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_grant & ~(req_valid & ~cpu_off)) == '0);
  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ready |-> req_grant == '0);
  assert_no_self_snoop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ((snp_inval | snp_share) & (N'(1) << resp_cpu)) == '0);
  assert_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_any |=> ((snp_inval | snp_share | snp_source) & $past(cpu_off)) == '0);
  assert_shared_no_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_state == ST_S) |-> (!mem_req_valid && snp_source != '0));
  assert_cold_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_state == ST_E) |->
      (mem_req_valid && !mem_req_write && (snp_inval | snp_share) == '0));
  assert_peer_data_no_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && snp_source != '0) |-> !mem_req_valid);
  assert_source_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(snp_source));
  assert_pulse_after_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
    grant_any |=> resp_valid);
  assert_quiet_without_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_any |=> (!resp_valid && !mem_req_valid));
endmodule

bind snoop_filter_ctrl snoop_filter_checker #(.N(N), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_off(cpu_off), .req_valid(req_valid),
  .mem_ready(mem_ready), .req_grant(req_grant), .grant_any(grant_any),
  .resp_valid(resp_valid), .resp_cpu(resp_cpu), .resp_state(resp_state),
  .snp_inval(snp_inval), .snp_share(snp_share), .snp_source(snp_source),
  .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write)
);

// File: tb/snoop_filter_ctrl_test.sv
module snoop_filter_ctrl_test;
  localparam int N = 4;
  localparam int AW = 16;
  localparam logic [1:0] I = 2'd0, S = 2'd1, E = 2'd2, M = 2'd3;
  localparam logic [1:0] RD = 2'd0, RFO = 2'd1, EV = 2'd2, WB = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] cpu_off = '0, req_valid = '0, req_full = '0;
  logic [2*N-1:0] req_op = '0;
  logic [AW*N-1:0] req_addr = '0;
  logic mem_ready = 1'b1;
  logic [N-1:0] req_grant, snp_inval, snp_share, snp_source;
  logic resp_valid, mem_req_valid, mem_req_write;
  logic [1:0] resp_cpu, resp_state;
  logic [AW-1:0] snp_addr, mem_req_addr;

  int errors = 0, checks = 0;

  snoop_filter_ctrl #(.N(N), .SETS(16), .AW(AW), .RUN(4)) uut (.*);

  always #4 clk = ~clk;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // raise a request at a negedge, wait for its grant, return at the negedge after the grant edge
  task automatic issue(input int cpu, input logic [1:0] op, input logic [AW-1:0] a, input bit full);
    int guard = 0;
    req_op[cpu*2 +: 2] = op;
    req_addr[cpu*AW +: AW] = a;
    req_full[cpu] = full;
    req_valid[cpu] = 1'b1;
    #1;
    while (!req_grant[cpu] && guard < 20) begin
      @(negedge clk);
      #1;
      guard++;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid[cpu] = 1'b0;
  endtask

  function automatic logic [63:0] pack(input logic [1:0] c, input logic [1:0] st, input logic [N-1:0] inv,
                                       input logic [N-1:0] sh, input logic [N-1:0] src,
                                       input logic mv, input logic mw, input logic [AW-1:0] a);
    return {23'd0, 1'b1, c, st, inv, sh, src, mv, mw, a, a};
  endfunction

  task automatic run_check(input int cpu, input logic [1:0] op, input logic [AW-1:0] a, input bit full,
                           input logic [1:0] st, input logic [N-1:0] inv, input logic [N-1:0] sh,
                           input logic [N-1:0] src, input logic mv, input logic mw, input string tag);
    logic [63:0] act, exp;
    issue(cpu, op, a, full);
    act = {23'd0, resp_valid, resp_cpu, resp_state, snp_inval, snp_share, snp_source,
           mem_req_valid, mem_req_write, snp_addr, mem_req_addr};
    exp = pack(2'(cpu), st, inv, sh, src, mv, mw, a);
    check(act == exp, tag, act, exp);
  endtask

  task automatic t_reset();
    check({resp_valid, mem_req_valid, req_grant, snp_inval, snp_share, snp_source} == '0, "R1 reset idle",
          64'({resp_valid, mem_req_valid, req_grant, snp_inval, snp_share, snp_source}), 64'd0);
  endtask

  task automatic t_sharing_chain();
    logic [AW-1:0] a = 16'h0013;
    run_check(0, RD,  a, 0, E, 4'b0000, 4'b0000, 4'b0000, 1, 0, "R1 cold read exclusive");
    run_check(1, RD,  a, 0, S, 4'b0000, 4'b0001, 4'b0001, 0, 0, "R2 R3 share from exclusive holder");
    run_check(2, RD,  a, 0, S, 4'b0000, 4'b0011, 4'b0001, 0, 0, "R3 lowest clean holder sources");
    run_check(3, RFO, a, 0, M, 4'b0111, 4'b0000, 4'b0001, 0, 0, "R5 ownership invalidates holders");
    run_check(0, RD,  a, 0, M, 4'b1000, 4'b0000, 4'b1000, 0, 0, "R4 dirty migrates to reader");
    run_check(1, RD,  a, 0, M, 4'b0001, 4'b0000, 4'b0001, 0, 0, "R4 second migration");
  endtask

  task automatic t_power();
    logic [AW-1:0] a = 16'h0013;
    cpu_off = 4'b0010;
    run_check(2, RD, a, 0, E, 4'b0000, 4'b0000, 4'b0000, 1, 0, "R7 powered-down owner ignored");
    req_op[1*2 +: 2] = RD;
    req_addr[1*AW +: AW] = 16'h0777;
    req_valid[1] = 1'b1;
    #1;
    check(req_grant == '0, "R7 request from powered-down cpu", 64'(req_grant), 64'd0);
    @(negedge clk);
    #1;
    check(req_grant == '0 && !resp_valid, "R7 still no grant", 64'({resp_valid, req_grant}), 64'd0);
    req_valid[1] = 1'b0;
    @(negedge clk);
    cpu_off = '0;
  endtask

  task automatic t_evict();
    logic [AW-1:0] b = 16'h0025;
    run_check(0, RD, b, 0, E, 4'b0000, 4'b0000, 4'b0000, 1, 0, "R1 cold read line B");
    run_check(0, EV, b, 0, I, 4'b0000, 4'b0000, 4'b0000, 0, 0, "R6 eviction silent");
    run_check(1, RD, b, 0, E, 4'b0000, 4'b0000, 4'b0000, 1, 0, "R6 evicted entry gone");
    run_check(1, WB, b, 0, I, 4'b0000, 4'b0000, 4'b0000, 1, 1, "R6 writeback memory write");
    run_check(2, RD, b, 0, E, 4'b0000, 4'b0000, 4'b0000, 1, 0, "R6 written-back entry gone");
    run_check(3, RFO, 16'h0037, 0, M, 4'b0000, 4'b0000, 4'b0000, 1, 0, "R5 ownership from memory");
  endtask

  task automatic t_round_robin();
    logic [AW-1:0] x = 16'h0049;
    logic [N-1:0] done = '0;
    int order [N];
    for (int c = 0; c < N; c++) begin
      req_op[c*2 +: 2] = RD;
      req_addr[c*AW +: AW] = x;
      req_full[c] = 1'b0;
    end
    req_valid = '1;
    for (int k = 0; k < N; k++) begin
      logic [63:0] act, exp;
      int g = 0;
      #1;
      for (int c = 0; c < N; c++) if (req_grant[c]) g = c;
      check($countones(req_grant) == 1 && !done[g], "R9 single new grant", 64'(req_grant), 64'(1 << g));
      order[k] = g;
      @(posedge clk);
      @(negedge clk);
      req_valid[g] = 1'b0;
      act = {23'd0, resp_valid, resp_cpu, resp_state, snp_inval, snp_share, snp_source,
             mem_req_valid, mem_req_write, snp_addr, mem_req_addr};
      if (k == 0) exp = pack(2'(g), E, '0, '0, '0, 1, 0, x);
      else exp = pack(2'(g), S, '0, done, done & (~done + 1'b1), 0, 0, x);
      check(act == exp, "R11 back-to-back sees prior update", act, exp);
      done[g] = 1'b1;
    end
    for (int k = 1; k < N; k++)
      check(order[k] == (order[k-1] + 1) % N, "R9 rotation order", 64'(order[k]), 64'((order[k-1] + 1) % N));
  endtask

  task automatic t_backoff();
    for (int k = 0; k < 5; k++) begin
      if (k < 3) run_check(1, RFO, 16'h0100 + 16'(k), 1, M, '0, '0, '0, 1, 0, "R8 early streaming writes allocate");
      else       run_check(1, RFO, 16'h0100 + 16'(k), 1, I, '0, '0, '0, 1, 1, "R8 fourth sequential write bypasses");
    end
    run_check(1, RD,  16'h0300, 0, E, '0, '0, '0, 1, 0, "R8 read miss in stream");
    run_check(1, RFO, 16'h0105, 1, M, '0, '0, '0, 1, 0, "R8 read restarts run");
    run_check(1, RFO, 16'h0106, 1, M, '0, '0, '0, 1, 0, "R8 run two");
    run_check(1, RFO, 16'h0107, 1, M, '0, '0, '0, 1, 0, "R8 run three");
    run_check(1, RFO, 16'h0200, 1, M, '0, '0, '0, 1, 0, "R8 non-sequential restarts run");
    run_check(1, RFO, 16'h0201, 1, M, '0, '0, '0, 1, 0, "R8 restarted run two");
  endtask

  task automatic t_mem_stall();
    mem_ready = 1'b0;
    req_op[2*2 +: 2] = RD;
    req_addr[2*AW +: AW] = 16'h0500;
    req_valid[2] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      check(req_grant == '0, "R10 no grant while memory busy", 64'(req_grant), 64'd0);
      @(negedge clk);
    end
    mem_ready = 1'b1;
    #1;
    check(req_grant == 4'b0100, "R10 grant once memory ready", 64'(req_grant), 64'h4);
    @(posedge clk);
    @(negedge clk);
    req_valid[2] = 1'b0;
    check(resp_valid && resp_state == E && mem_req_valid, "R10 stalled request completes",
          64'({resp_valid, resp_state, mem_req_valid}), 64'({1'b1, E, 1'b1}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sharing_chain();
    t_power();
    t_evict();
    t_round_robin();
    t_backoff();
    t_mem_stall();
    @(negedge clk);
    finish_run();
  end
endmodule